// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit with Shifter

This block is a 4-bit arithmetic and logic unit for a small processor datapath. Two operand buses, A and B, feed one result bus and four status flags. A complementor takes either bus and produces its bitwise inverse. That inverse can stand in for the adder's second operand, so subtraction and negation reuse the single adder. A shifter works only on bus A. It provides plain shifts, rotates, shifts that pull in an external carry bit, and rotates through carry. For right shifts, a control input chooses between sign fill and zero fill.

A 4-bit opcode selects one of eleven operations. The five codes above the last operation drive the result and all flags to zero. By default the result and flags are captured in an output holding register. That register has a synchronous active-high reset, so a new operation appears on the outputs one clock after its inputs are applied. The block has no multiply or divide, and it holds no architectural registers.

Flag positions on the flags output are: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 signed overflow (V). The complementor source select `csel_i` picks bus A when it is 0 and bus B when it is 1. The shift direction `dir_i` is left when 0 and right when 1.

Top module: `nib_alu`

## Requirements
- R1: Opcodes 0x0, 0x1 and 0x2 give A AND B, A OR B and A XOR B. C and V are 0 for these codes, and `cin_i` and `sext_i` have no effect on them.
- R2: Opcode 0x3 gives the bitwise NOT of the complementor source. Opcode 0x4 gives its two's complement, computed as 0 + NOT(source) + 1. For 0x4, C is the carry out of that sum (1 only for a zero source). The complementor source is A when `csel_i`=0 and B when `csel_i`=1.
- R3: Opcode 0x5 gives A + B modulo 16, and C is the carry out of bit 3. `cin_i` is not added.
- R4: Opcode 0x6 gives A + NOT(source) + 1, which is A minus the complementor source. C=1 means no borrow.
- R5: For opcodes 0x4, 0x5 and 0x6, V is 1 exactly when both adder operands have the same sign bit and the result sign differs from it. For every other opcode, V is 0.
- R6: Opcode 0x7 is a plain shift. A left shift fills bit 0 with 0. A right shift fills bit 3 with A[3] when `sext_i`=1 and with 0 otherwise. C gets the bit shifted out (A[3] on a left shift, A[0] on a right shift).
- R7: Opcode 0x8 rotates A by one position, so the bit shifted out re-enters at the other end. C gets that bit, and `sext_i` has no effect.
- R8: Opcode 0x9 shifts A by one position and fills the vacated bit with `cin_i`. C equals `cin_i`.
- R9: Opcode 0xA rotates through carry. The vacated bit is filled with `cin_i`, and C gets the bit shifted out.
- R10: Z is 1 exactly when the result is zero and the opcode is 0x0 to 0xA. N always equals result bit 3.
- R11: Opcodes 0xB to 0xF drive the result and all four flags to 0.
- R12: The result and flags change only at a rising clock edge and reflect the inputs seen at that edge. While `rst` is high at an edge, both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output holding register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation select code |
| a_i | input | 4 | Operand bus A |
| b_i | input | 4 | Operand bus B |
| cin_i | input | 1 | Carry bit used by the carry-fill shift and the rotate through carry |
| sext_i | input | 1 | Sign fill for plain right shifts |
| csel_i | input | 1 | Complementor source: 0 for A, 1 for B |
| dir_i | input | 1 | Shift direction: 0 for left, 1 for right |
| res_o | output | 4 | Result bus |
| flags_o | output | 4 | Flags {V, N, Z, C} |

## Verification
The properties assume that every input is known and stable at each rising edge. They also assume that the output holding register is present, because each output is compared against the inputs captured one cycle earlier. The bench changes inputs only on the falling edge and never leaves an input undriven. The first comparison after reset is allowed only once a full non-reset cycle has passed, so no check reads the operands of a cycle spent in reset.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int NIB_W = 4;
    localparam int OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'h0,
        OP_OR  = 4'h1,
        OP_XOR = 4'h2,
        OP_NOT = 4'h3,
        OP_NEG = 4'h4,
        OP_ADD = 4'h5,
        OP_SUB = 4'h6,
        OP_SHF = 4'h7,
        OP_ROT = 4'h8,
        OP_SHC = 4'h9,
        OP_RTC = 4'hA
    } nib_op_e;

    localparam logic [OP_W-1:0] OP_LAST = OP_RTC;

    typedef enum logic [1:0] {
        SH_PLAIN = 2'd0,
        SH_ROT   = 2'd1,
        SH_CIN   = 2'd2,
        SH_RTC   = 2'd3
    } sh_mode_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } nib_flags_t;

    function automatic sh_mode_e shift_mode(input logic [OP_W-1:0] code);
        logic [OP_W-1:0] rel;
        rel = code - OP_SHF;
        return sh_mode_e'(rel[1:0]);
    endfunction

    function automatic logic is_arith(input logic [OP_W-1:0] code);
        return (code == OP_NEG) || (code == OP_ADD) || (code == OP_SUB);
    endfunction

endpackage

// File: rtl/nib_cmpl.sv
module nib_cmpl #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_b_i,
    output logic [W-1:0] inv_o
);

    logic [W-1:0] src;

    assign src   = sel_b_i ? b_i : a_i;
    assign inv_o = ~src;

endmodule

// File: rtl/nib_adder.sv
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ovf_o
);

    localparam int WX = W + 1;

    logic [WX-1:0] wide;

    assign wide  = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i};
    assign sum_o = wide[W-1:0];
    assign co_o  = wide[W];
    assign ovf_o = (x_i[W-1] == y_i[W-1]) && (wide[W-1] != x_i[W-1]);

endmodule

// File: rtl/nib_shifter.sv
module nib_shifter
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  sh_mode_e     mode_i,
    input  logic         right_i,
    input  logic         sext_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    logic out_bit;
    logic fill;

    assign out_bit = right_i ? a_i[0] : a_i[W-1];

    always_comb begin
        case (mode_i)
            SH_PLAIN: fill = right_i & sext_i & a_i[W-1];
            SH_ROT:   fill = out_bit;
            default:  fill = cin_i;
        endcase
    end

    assign res_o  = right_i ? {fill, a_i[W-1:1]} : {a_i[W-2:0], fill};
    assign cout_o = (mode_i == SH_CIN) ? cin_i : out_bit;

endmodule

// File: rtl/nib_flag_unit.sv
module nib_flag_unit
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] res_i,
    input  logic         c_i,
    input  logic         v_i,
    input  logic         valid_i,
    output nib_flags_t   flags_o
);

    always_comb begin
        flags_o.c = valid_i & c_i;
        flags_o.v = valid_i & v_i;
        flags_o.z = valid_i & (res_i == '0);
        flags_o.n = res_i[W-1];
    end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int W       = NIB_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            cin_i,
    input  logic            sext_i,
    input  logic            csel_i,
    input  logic            dir_i,
    output logic [W-1:0]    res_o,
    output logic [3:0]      flags_o
);

    logic [W-1:0] inv;
    logic [W-1:0] add_x, add_y, sum;
    logic         add_ci, add_co, add_v;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic [W-1:0] r_comb;
    logic         c_comb, v_comb, valid;
    nib_flags_t   fl_comb;
    nib_op_e      op;

    assign op    = nib_op_e'(op_i);
    assign valid = (op_i <= OP_LAST);

    nib_cmpl #(.W(W)) u_cmpl (
        .a_i     (a_i),
        .b_i     (b_i),
        .sel_b_i (csel_i),
        .inv_o   (inv)
    );

    always_comb begin
        add_x  = a_i;
        add_y  = b_i;
        add_ci = 1'b0;
        case (op)
            OP_SUB: begin
                add_y  = inv;
                add_ci = 1'b1;
            end
            OP_NEG: begin
                add_x  = '0;
                add_y  = inv;
                add_ci = 1'b1;
            end
            default: ;
        endcase
    end

    nib_adder #(.W(W)) u_add (
        .x_i   (add_x),
        .y_i   (add_y),
        .ci_i  (add_ci),
        .sum_o (sum),
        .co_o  (add_co),
        .ovf_o (add_v)
    );

    nib_shifter #(.W(W)) u_shf (
        .a_i     (a_i),
        .mode_i  (shift_mode(op_i)),
        .right_i (dir_i),
        .sext_i  (sext_i),
        .cin_i   (cin_i),
        .res_o   (sh_res),
        .cout_o  (sh_c)
    );

    always_comb begin
        r_comb = '0;
        c_comb = 1'b0;
        v_comb = 1'b0;
        case (op)
            OP_AND: r_comb = a_i & b_i;
            OP_OR:  r_comb = a_i | b_i;
            OP_XOR: r_comb = a_i ^ b_i;
            OP_NOT: r_comb = inv;
            OP_NEG, OP_ADD, OP_SUB: begin
                r_comb = sum;
                c_comb = add_co;
                v_comb = add_v;
            end
            OP_SHF, OP_ROT, OP_SHC, OP_RTC: begin
                r_comb = sh_res;
                c_comb = sh_c;
            end
            default: ;
        endcase
    end

    nib_flag_unit #(.W(W)) u_flg (
        .res_i   (r_comb),
        .c_i     (c_comb),
        .v_i     (v_comb),
        .valid_i (valid),
        .flags_o (fl_comb)
    );

    generate
        if (REG_OUT) begin : g_hold
            logic [W-1:0] res_q;
            nib_flags_t   fl_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    fl_q  <= '0;
                end else begin
                    res_q <= r_comb;
                    fl_q  <= fl_comb;
                end
            end
            assign res_o   = res_q;
            assign flags_o = fl_q;
        end else begin : g_comb
            assign res_o   = r_comb;
            assign flags_o = fl_comb;
        end
    endgenerate

endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
#(
    parameter int W       = NIB_W,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic            csel_i,
    input logic [W-1:0]    res_o,
    input logic [3:0]      flags_o
);

    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    generate
        if (REG_OUT) begin : g_props
            p_reset_clear_r12: assert property (@(posedge clk)
                rst |=> (res_o == '0 && flags_o == '0));

            p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) > OP_LAST) |-> (res_o == '0 && flags_o == '0));

            p_logic_no_cv_r1: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) <= OP_XOR) |-> (flags_o[0] == 1'b0 && flags_o[3] == 1'b0));

            p_sub_inverse_r4: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) == OP_SUB && $past(csel_i))
                |-> (W'(res_o + $past(b_i)) == $past(a_i)));

            p_add_overflow_r5: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) == OP_ADD)
                |-> (flags_o[3] == (($past(a_i[W-1]) == $past(b_i[W-1]))
                                    && (res_o[W-1] != $past(a_i[W-1])))));

            p_no_v_outside_arith_r5: assert property (@(posedge clk) disable iff (rst)
                (seen && !is_arith($past(op_i))) |-> (flags_o[3] == 1'b0));

            p_rotate_keeps_ones_r7: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) == OP_ROT)
                |-> ($countones(res_o) == $countones($past(a_i))));

            p_zero_flag_r10: assert property (@(posedge clk) disable iff (rst)
                (seen && $past(op_i) <= OP_LAST) |-> (flags_o[1] == (res_o == '0)));

            p_neg_flag_r10: assert property (@(posedge clk) disable iff (rst)
                seen |-> (flags_o[2] == res_o[W-1]));
        end
    endgenerate

endmodule

bind nib_alu nib_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .csel_i  (csel_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/sim_nib_alu.sv
module sim_nib_alu;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op, a, b;
    logic       cin, sext, csel, dir;
    logic [3:0] res, flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nib_alu u0 (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
        .cin_i(cin), .sext_i(sext), .csel_i(csel), .dir_i(dir),
        .res_o(res), .flags_o(flags)
    );

    // Each entry: {req, op, a, b, {cin,sext,csel,dir}, res, flags{V,N,Z,C}}
    localparam int NV = 33;
    localparam logic [27:0] VEC [NV] = '{
        {4'd1,  4'h0, 4'hC, 4'hA, 4'b0000, 4'h8, 4'b0100}, // R1 and
        {4'd1,  4'h1, 4'hC, 4'h3, 4'b0000, 4'hF, 4'b0100}, // R1 or
        {4'd1,  4'h2, 4'h5, 4'h5, 4'b0000, 4'h0, 4'b0010}, // R1 xor to zero
        {4'd1,  4'h0, 4'hF, 4'hF, 4'b1100, 4'hF, 4'b0100}, // R1 cin/sext ignored
        {4'd2,  4'h3, 4'h0, 4'h3, 4'b0010, 4'hC, 4'b0100}, // R2 not of B
        {4'd2,  4'h3, 4'hF, 4'h0, 4'b0000, 4'h0, 4'b0010}, // R2 not of A
        {4'd2,  4'h4, 4'h0, 4'h3, 4'b0010, 4'hD, 4'b0100}, // R2 negate B
        {4'd2,  4'h4, 4'h8, 4'h0, 4'b0000, 4'h8, 4'b1100}, // R2 negate -8
        {4'd2,  4'h4, 4'h5, 4'h0, 4'b0010, 4'h0, 4'b0011}, // R2 negate zero
        {4'd3,  4'h5, 4'h7, 4'h1, 4'b0000, 4'h8, 4'b1100}, // R3 add pos ovf
        {4'd3,  4'h5, 4'hF, 4'h1, 4'b0000, 4'h0, 4'b0011}, // R3 add wrap
        {4'd5,  4'h5, 4'h9, 4'hA, 4'b0000, 4'h3, 4'b1001}, // R5 add neg ovf
        {4'd3,  4'h5, 4'h2, 4'h3, 4'b1000, 4'h5, 4'b0000}, // R3 cin not added
        {4'd4,  4'h6, 4'h5, 4'h3, 4'b0010, 4'h2, 4'b0001}, // R4 5-3
        {4'd4,  4'h6, 4'h3, 4'h5, 4'b0010, 4'hE, 4'b0100}, // R4 borrow
        {4'd5,  4'h6, 4'h8, 4'h1, 4'b0010, 4'h7, 4'b1001}, // R5 sub ovf
        {4'd4,  4'h6, 4'h6, 4'h2, 4'b0000, 4'h0, 4'b0011}, // R4 source A
        {4'd6,  4'h7, 4'h9, 4'h0, 4'b0000, 4'h2, 4'b0001}, // R6 shl
        {4'd6,  4'h7, 4'h9, 4'h0, 4'b0001, 4'h4, 4'b0001}, // R6 shr zero fill
        {4'd6,  4'h7, 4'h9, 4'h0, 4'b0101, 4'hC, 4'b0101}, // R6 shr sign fill
        {4'd6,  4'h7, 4'h6, 4'h0, 4'b0101, 4'h3, 4'b0000}, // R6 shr pos sign
        {4'd6,  4'h7, 4'h6, 4'h0, 4'b0100, 4'hC, 4'b0100}, // R6 sext no effect left
        {4'd7,  4'h8, 4'h9, 4'h0, 4'b0000, 4'h3, 4'b0001}, // R7 rol
        {4'd7,  4'h8, 4'h9, 4'h0, 4'b0001, 4'hC, 4'b0101}, // R7 ror
        {4'd7,  4'h8, 4'h8, 4'h0, 4'b0101, 4'h4, 4'b0000}, // R7 sext ignored
        {4'd8,  4'h9, 4'h8, 4'h0, 4'b1000, 4'h1, 4'b0001}, // R8 left cin=1
        {4'd8,  4'h9, 4'h1, 4'h0, 4'b0001, 4'h0, 4'b0010}, // R8 right cin=0
        {4'd8,  4'h9, 4'h8, 4'h0, 4'b0000, 4'h0, 4'b0010}, // R8 carry = cin
        {4'd9,  4'hA, 4'h8, 4'h0, 4'b0000, 4'h0, 4'b0011}, // R9 left out bit
        {4'd9,  4'hA, 4'h1, 4'h0, 4'b1001, 4'h8, 4'b0101}, // R9 right cin in
        {4'd9,  4'hA, 4'h8, 4'h0, 4'b0101, 4'h4, 4'b0000}, // R9 sext ignored
        {4'd11, 4'hB, 4'hF, 4'hF, 4'b1111, 4'h0, 4'b0000}, // R11 code B
        {4'd11, 4'hF, 4'h0, 4'h0, 4'b0000, 4'h0, 4'b0000}  // R11 code F, no Z (R10)
    };

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [3:0] x, input logic [3:0] y,
                         input logic [3:0] ctl);
        op = o; a = x; b = y;
        {cin, sext, csel, dir} = ctl;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(4'h5, 4'h3, 4'h4, 4'b0000);
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset result", res, 4'h0);
        check("R12 reset flags", flags, 4'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            drive(v[23:20], v[19:16], v[15:12], v[11:8]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d result", v[27:24], i), res, v[7:4]);
            check($sformatf("R%0d vec %0d flags", v[27:24], i), flags, v[3:0]);
        end

        // R12: output holds until the next rising edge
        drive(4'h5, 4'h1, 4'h1, 4'b0000);
        @(negedge clk);
        check("R12 captured result", res, 4'h2);
        drive(4'h1, 4'h8, 4'h4, 4'b0000);
        #5;
        check("R12 hold before edge", res, 4'h2);
        @(negedge clk);
        check("R12 new value after edge", res, 4'hC);
        check("R10 N flag after edge", flags, 4'b0100);

        // R12: synchronous reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R12 mid reset result", res, 4'h0);
        check("R12 mid reset flags", flags, 4'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 resume after reset", res, 4'hC);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule